// File: doc/BRIEF.md
# Receive FIFO with Line Status

This block holds received characters for a serial receiver and reports the receive-side line status to a host. Each character enters through a write port together with three tags (parity error, framing error, break). The characters wait in a 16-deep queue, or in a single holding slot when queue mode is off. The host pops the head character with a data-read strobe. An 8-bit status word reports the following: whether data is waiting, whether a character was lost to an overrun, the tags of the head character only, the transmitter occupancy, and an aggregate flag. The aggregate flag says that a tagged character has been seen and has not yet been acknowledged.

A status-read strobe acknowledges the sticky bits. It clears the overrun flag and hides the tags of the current head until that head is popped. It clears the aggregate flag only when no tagged character is left in the queue. The block raises a receiver-line-status interrupt request when that interrupt is enabled and any reportable receive error is visible. Changing the queue-mode input empties the storage.

Top module: `rx_line_status`

## Requirements
- R1: Status bit 0 (data ready) is 1 exactly while at least one character is stored. A data-read strobe removes the head character, and characters leave in arrival order on `rd_data_o`.
- R2: Capacity is 16 characters when `fifo_en_i` is 1 and one character when it is 0. A write is accepted when the store is not full or a pop happens in the same cycle. A write to a full store with no pop is discarded, and the stored characters are unchanged.
- R3: Status bit 1 (overrun) becomes 1 in the cycle after a discarded write. It stays 1 until a status-read strobe. If a new overrun coincides with the strobe, the bit stays 1.
- R4: Status bits 2, 3 and 4 (parity, framing, break) show the tags of the head character only. They are 0 when the store is empty.
- R5: A status-read strobe while a character is stored hides the head's tags from the next cycle on. The next character to reach the head shows its own tags again.
- R6: In queue mode, status bit 7 becomes 1 after a tagged character is accepted. A status-read strobe clears it only if no tagged character remains stored after that cycle. Otherwise it stays 1.
- R7: Status bit 7 is 0 whenever `fifo_en_i` is 0, even after tagged characters are accepted.
- R8: Status bit 5 equals `thr_empty_i`. Status bit 6 is 1 only when `thr_empty_i` and `tsr_empty_i` are both 1.
- R9: `rls_irq_o` is 1 exactly when `rls_ie_i` is 1 and at least one of status bits 1 to 4 is 1.
- R10: A change of `fifo_en_i` empties the store and clears the overrun and aggregate flags by the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | 1: 16-deep queue mode, 0: single holding slot |
| wr_valid_i | input | 1 | Receiver delivers a character this cycle |
| wr_data_i | input | 8 | Received character |
| wr_pe_i | input | 1 | Parity-error tag of the character |
| wr_fe_i | input | 1 | Framing-error tag of the character |
| wr_bi_i | input | 1 | Break tag of the character |
| rd_data_i | input | 1 | Host data-read strobe, pops the head |
| rd_lsr_i | input | 1 | Host status-read strobe |
| thr_empty_i | input | 1 | Transmit holding storage is empty |
| tsr_empty_i | input | 1 | Transmit shift register is empty |
| rls_ie_i | input | 1 | Line-status interrupt enable |
| rd_data_o | output | 8 | Head character |
| lsr_o | output | 8 | Status word: DR, OE, PE, FE, BI, THRE, TEMT, FIFOERR from bit 0 to 7 |
| rls_irq_o | output | 1 | Receiver-line-status interrupt request |

## Verification
The bench mixes clean and tagged characters and checks that each tag becomes visible only when its own character reaches the head. A design that ORs tags across the queue, or shows them at write time, reports errors against clean characters. It reads status while a tagged character is at the head and checks that the tag is hidden afterwards but the aggregate flag stays up while other tagged characters remain. A design that clears the aggregate flag unconditionally, or counts tags wrongly, fails these checks. It overfills the queue and the single slot to catch a design that overwrites stored data or loses the overrun flag, and it checks bit 7 and the interrupt request against the mode and enable inputs.

// File: rtl/rx_lsr_pkg.sv
package rx_lsr_pkg;
  typedef struct packed {
    logic       bi;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_entry_t;

  localparam int unsigned LSR_DR   = 0;
  localparam int unsigned LSR_OE   = 1;
  localparam int unsigned LSR_PE   = 2;
  localparam int unsigned LSR_FE   = 3;
  localparam int unsigned LSR_BI   = 4;
  localparam int unsigned LSR_THRE = 5;
  localparam int unsigned LSR_TEMT = 6;
  localparam int unsigned LSR_FERR = 7;
endpackage

// File: rtl/rx_char_store.sv
module rx_char_store
  import rx_lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      flush_i,
  input  logic      fifo_mode_i,
  input  logic      push_i,
  input  rx_entry_t push_entry_i,
  input  logic      pop_i,
  output rx_entry_t head_o,
  output logic [CW-1:0] count_o,
  output logic      empty_o,
  output logic      accept_o,
  output logic      pop_o,
  output logic      overrun_o
);
  rx_entry_t mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic full;

  assign empty_o   = (cnt_q == '0);
  assign full      = fifo_mode_i ? (cnt_q == CW'(DEPTH)) : !empty_o;
  assign pop_o     = pop_i && !empty_o && !flush_i;
  assign accept_o  = push_i && !flush_i && (!full || pop_o);
  assign overrun_o = push_i && !flush_i && full && !pop_o;
  assign head_o    = mem_q[rptr_q];
  assign count_o   = cnt_q;

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (accept_o) wptr_q <= inc_ptr(wptr_q);
      if (pop_o)    rptr_q <= inc_ptr(rptr_q);
      cnt_q <= cnt_q + CW'(accept_o) - CW'(pop_o);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (accept_o && wptr_q == AW'(i)) mem_q[i] <= push_entry_i;
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_single_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_mode_i && !flush_i) |=> cnt_q <= CW'(1) || $changed(fifo_mode_i));
  p_full_keeps_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> $stable(cnt_q));
endmodule

// File: rtl/rx_tag_tracker.sv
module rx_tag_tracker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic fifo_mode_i,
  input  logic wr_tag_i,
  input  logic accept_i,
  input  logic pop_i,
  input  logic pop_tag_i,
  input  logic rd_lsr_i,
  output logic [CW-1:0] tag_cnt_o,
  output logic fifo_err_o
);
  logic [CW-1:0] tag_cnt_q, tag_cnt_d;
  logic err_q, add_tag, drop_tag;

  assign add_tag   = accept_i && wr_tag_i;
  assign drop_tag  = pop_i && pop_tag_i;
  assign tag_cnt_d = tag_cnt_q + CW'(add_tag) - CW'(drop_tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_cnt_q <= '0;
      err_q     <= 1'b0;
    end else if (flush_i) begin
      tag_cnt_q <= '0;
      err_q     <= 1'b0;
    end else begin
      tag_cnt_q <= tag_cnt_d;
      // a read acknowledges only when nothing tagged is left behind
      if (add_tag && fifo_mode_i) err_q <= 1'b1;
      else if (rd_lsr_i && tag_cnt_d == '0) err_q <= 1'b0;
    end
  end

  assign tag_cnt_o  = tag_cnt_q;
  assign fifo_err_o = err_q && fifo_mode_i;

  p_err_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode_i && !flush_i && tag_cnt_d != '0 && err_q) |=> err_q);
  p_err_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_tag && fifo_mode_i && !flush_i) |=> err_q);
endmodule

// File: rtl/rx_status_word.sv
module rx_status_word
  import rx_lsr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      flush_i,
  input  logic      empty_i,
  input  logic      pop_i,
  input  logic      overrun_i,
  input  logic      rd_lsr_i,
  input  rx_entry_t head_i,
  input  logic      fifo_err_i,
  input  logic      thr_empty_i,
  input  logic      tsr_empty_i,
  output logic [7:0] lsr_o
);
  logic oe_q, mask_q;
  logic [2:0] head_tags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (flush_i)        oe_q <= 1'b0;
      else if (overrun_i) oe_q <= 1'b1;
      else if (rd_lsr_i)  oe_q <= 1'b0;
      // head tags stay hidden after a read until a new head arrives
      if (flush_i || pop_i || empty_i) mask_q <= 1'b0;
      else if (rd_lsr_i)               mask_q <= 1'b1;
    end
  end

  assign head_tags = (empty_i || mask_q) ? 3'b000 : {head_i.bi, head_i.fe, head_i.pe};

  always_comb begin
    lsr_o           = '0;
    lsr_o[LSR_DR]   = !empty_i;
    lsr_o[LSR_OE]   = oe_q;
    lsr_o[LSR_PE]   = head_tags[0];
    lsr_o[LSR_FE]   = head_tags[1];
    lsr_o[LSR_BI]   = head_tags[2];
    lsr_o[LSR_THRE] = thr_empty_i;
    lsr_o[LSR_TEMT] = thr_empty_i && tsr_empty_i;
    lsr_o[LSR_FERR] = fifo_err_i;
  end

  p_oe_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_i && !flush_i) |=> oe_q);
  p_oe_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lsr_i && !overrun_i) |=> !oe_q);
  p_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lsr_i && !empty_i && !pop_i && !flush_i) |=> lsr_o[4:2] == 3'b000);
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import rx_lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fifo_en_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  input  logic       wr_pe_i,
  input  logic       wr_fe_i,
  input  logic       wr_bi_i,
  input  logic       rd_data_i,
  input  logic       rd_lsr_i,
  input  logic       thr_empty_i,
  input  logic       tsr_empty_i,
  input  logic       rls_ie_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] lsr_o,
  output logic       rls_irq_o
);
  logic mode_q, flush;
  rx_entry_t wr_entry, head;
  logic [CW-1:0] count, tag_cnt;
  logic empty, accept, pop, overrun, fifo_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= fifo_en_i;
  end
  assign flush = (mode_q != fifo_en_i);

  assign wr_entry = '{bi: wr_bi_i, fe: wr_fe_i, pe: wr_pe_i, data: wr_data_i};

  rx_char_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .flush_i     (flush),
    .fifo_mode_i (fifo_en_i),
    .push_i      (wr_valid_i),
    .push_entry_i(wr_entry),
    .pop_i       (rd_data_i),
    .head_o      (head),
    .count_o     (count),
    .empty_o     (empty),
    .accept_o    (accept),
    .pop_o       (pop),
    .overrun_o   (overrun)
  );

  rx_tag_tracker #(.DEPTH(DEPTH)) u_tags (
    .clk_i, .rst_ni,
    .flush_i     (flush),
    .fifo_mode_i (fifo_en_i),
    .wr_tag_i    (wr_pe_i | wr_fe_i | wr_bi_i),
    .accept_i    (accept),
    .pop_i       (pop),
    .pop_tag_i   (head.pe | head.fe | head.bi),
    .rd_lsr_i    (rd_lsr_i),
    .tag_cnt_o   (tag_cnt),
    .fifo_err_o  (fifo_err)
  );

  rx_status_word u_status (
    .clk_i, .rst_ni,
    .flush_i     (flush),
    .empty_i     (empty),
    .pop_i       (pop),
    .overrun_i   (overrun),
    .rd_lsr_i    (rd_lsr_i),
    .head_i      (head),
    .fifo_err_i  (fifo_err),
    .thr_empty_i (thr_empty_i),
    .tsr_empty_i (tsr_empty_i),
    .lsr_o       (lsr_o)
  );

  assign rd_data_o = head.data;
  assign rls_irq_o = rls_ie_i && (lsr_o[LSR_BI:LSR_OE] != '0);

  p_tag_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_cnt <= count);
  p_drain_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && count == CW'(1) && !accept && !flush) |=> !lsr_o[LSR_DR]);
  p_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (count == '0 && !lsr_o[LSR_OE]));
  p_irq_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rls_irq_o |-> (rls_ie_i && !empty) || lsr_o[LSR_OE]);
endmodule

// File: tb/tb_rx_line_status.sv
module tb_rx_line_status;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic fifo_en = 1, wr_valid = 0, wr_pe = 0, wr_fe = 0, wr_bi = 0;
  logic [7:0] wr_data = 0;
  logic rd_data = 0, rd_lsr = 0, thr_e = 1, tsr_e = 1, ie = 1;
  logic [7:0] rdat, lsr;
  logic irq;

  int checks = 0, errors = 0;
  logic [10:0] sb[$];   // {bi,fe,pe,data}
  bit hidden = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_line_status dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .wr_valid_i(wr_valid),
    .wr_data_i(wr_data), .wr_pe_i(wr_pe), .wr_fe_i(wr_fe), .wr_bi_i(wr_bi),
    .rd_data_i(rd_data), .rd_lsr_i(rd_lsr), .thr_empty_i(thr_e),
    .tsr_empty_i(tsr_e), .rls_ie_i(ie), .rd_data_o(rdat), .lsr_o(lsr),
    .rls_irq_o(irq));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(logic [7:0] d, bit pe, bit fe, bit bi, bit acc);
    wr_valid = 1; wr_data = d; wr_pe = pe; wr_fe = fe; wr_bi = bi;
    tick();
    wr_valid = 0; wr_pe = 0; wr_fe = 0; wr_bi = 0;
    if (acc) begin
      sb.push_back({bi, fe, pe, d});
      if (sb.size() == 1) hidden = 0;
    end
  endtask

  // monitor: compare head against scoreboard, then pop
  task automatic pop_chk();
    logic [10:0] e;
    e = sb.pop_front();
    chk(rdat == e[7:0], "R1 data order", rdat, e[7:0]);
    chk(lsr[4:2] == (hidden ? 3'b000 : e[10:8]), "R4 head tags", lsr[4:2],
        hidden ? 0 : e[10:8]);
    rd_data = 1; tick(); rd_data = 0;
    hidden = 0;
  endtask

  task automatic read_lsr();
    rd_lsr = 1; tick(); rd_lsr = 0;
    if (sb.size() != 0) hidden = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1; tick(); tick();
    chk(lsr == 8'h60, "R8 reset status", lsr, 8'h60);
    chk(irq == 0, "R9 reset irq", irq, 0);

    // tags surface only at the head
    push(8'h11, 0, 0, 0, 1);
    push(8'h22, 1, 0, 0, 1);
    push(8'h33, 0, 0, 0, 1);
    push(8'h44, 0, 1, 0, 1);
    chk(lsr == 8'he1, "R4 clean head, R6 aggregate set", lsr, 8'he1);
    chk(irq == 0, "R9 no irq on clean head", irq, 0);
    pop_chk();
    chk(lsr[2] == 1 && irq == 1, "R4 R9 parity at head", {lsr[2], irq}, 2'b11);
    read_lsr();
    chk(lsr[4:2] == 0 && lsr[7] == 1, "R5 hidden, R6 kept", lsr, 8'he1);
    pop_chk();
    pop_chk();
    chk(lsr[3] == 1, "R4 framing at head", lsr[3], 1);
    read_lsr();
    chk(lsr[3] == 0 && lsr[7] == 1, "R5 R6 framing read", lsr, 8'he1);
    pop_chk();
    chk(lsr == 8'he0, "R1 empty, R6 bit7 still set", lsr, 8'he0);
    read_lsr();
    chk(lsr == 8'h60, "R6 bit7 cleared", lsr, 8'h60);

    // overflow in queue mode
    for (int i = 0; i < 16; i++) push(8'(8'h80 + i), 0, (i == 5), 0, 1);
    chk(lsr[1] == 0, "R2 full, no overrun yet", lsr[1], 0);
    push(8'hee, 0, 0, 0, 0);
    chk(lsr[1] == 1 && irq == 1, "R3 overrun flagged", {lsr[1], irq}, 2'b11);
    ie = 0; tick();
    chk(irq == 0, "R9 disabled irq", irq, 0);
    ie = 1;
    read_lsr();
    chk(lsr[1] == 0, "R3 overrun cleared", lsr[1], 0);
    // overrun coinciding with status read keeps the flag
    wr_valid = 1; wr_data = 8'hdd; rd_lsr = 1; tick();
    wr_valid = 0; rd_lsr = 0; hidden = 1;
    chk(lsr[1] == 1, "R3 set wins over read", lsr[1], 1);
    read_lsr();
    while (sb.size() > 0) pop_chk();
    chk(lsr[0] == 0, "R1 drained", lsr[0], 0);
    read_lsr();
    chk(lsr[7] == 0, "R6 cleared after drain", lsr[7], 0);

    // single-slot mode
    push(8'h55, 0, 0, 0, 1);
    fifo_en = 0; tick(); sb.delete();
    chk(lsr[0] == 0, "R10 mode change empties", lsr[0], 0);
    push(8'h66, 0, 0, 1, 1);
    chk(lsr[4] == 1 && lsr[7] == 0, "R4 break, R7 bit7 off", lsr, 8'h71);
    push(8'h77, 0, 0, 0, 0);
    chk(lsr[1] == 1, "R2 single slot overrun", lsr[1], 1);
    pop_chk();
    chk(lsr[0] == 0 && lsr[7] == 0, "R7 still off", lsr, 8'h62);
    read_lsr();
    push(8'h12, 0, 0, 0, 1);
    fifo_en = 1; tick(); sb.delete(); hidden = 0;
    chk(lsr[1:0] == 0, "R10 flush on return", lsr, 8'h60);

    // transmitter status combinations
    thr_e = 0; tsr_e = 1; tick();
    chk(lsr[6:5] == 2'b00, "R8 holding busy", lsr[6:5], 0);
    thr_e = 1; tsr_e = 0; tick();
    chk(lsr[6:5] == 2'b01, "R8 shifter busy", lsr[6:5], 1);
    thr_e = 1; tsr_e = 1; tick();
    chk(lsr[6:5] == 2'b11, "R8 both empty", lsr[6:5], 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule